// File: doc/BRIEF.md
# Serial Request Packet Decoder

This block sits at the receive side of a narrow, double-data-rate packet bus and turns one serially delivered request into a set of decoded command fields. Eleven wires feed it: a command wire, an address wire and nine data wires. Each wire carries eight bit-times per packet window, and the window lasts four clock cycles. A front-end register stage upstream delivers each wire as a pair of bits per clock: the bit captured on the rising edge and the bit captured on the falling edge.

The decoder stays idle until a one appears in the start position on the command wire. It then gathers the next four cycles into a packet-wide word. From that word it splits out the device, bank, row and column address, the six operation bits, the activate and auto-precharge flags, the register-select flag, the pending-skip count and the write byte mask. For a request addressed to this device, or for any broadcast, it presents the fields together with a one-cycle valid pulse. A density parameter chooses between a two-bank and a four-bank address split.

Top module: `req_pkt_decoder`

## Requirements
- R1: While rst_n is low, and after reset until a request is decoded, rq_vld is 0 and every decoded output is 0; a start bit seen during reset has no effect.
- R2: Bit-time t of a packet arrives in cycle t/2, on pair bit 0 for even t (rising edge) and on pair bit 1 for odd t (falling edge). In idle, a 1 on cmd_pr[0] marks cycle 0 of a request. rq_vld rises in the cycle after cycle 3 has been sampled, and it lasts exactly one cycle.
- R3: A 1 in the start position (cmd_pr[0]) during cycles 1 to 3 of a request does not restart collection. A new request may begin in the cycle right after cycle 3.
- R4: Data wire d at bit-time t (t = 0..5) carries payload slot k = 6*d + t. Slots 0..32 hold address bits A3..A35. With FOUR_BANK = 1: column = A10..A3, row = A20..A11, bank = A22..A21, device = A35..A23.
- R5: With FOUR_BANK = 0: column = A10..A3, row = A19..A11, bank = A20, device = A35..A21. Narrower fields are zero-extended on the ports.
- R6: Command wire bit-times 1..6 carry OP0..OP5. OP0 = 1 means write, OP1 = 1 means register space, OP2 is the byte-mask option, OP3 is broadcast, and OP5..OP4 are the bit-mask options.
- R7: Address wire bit-time 0 is the activate flag, bit-time 1 is auto-precharge, bit-time 2 is register-select, and bit-times 3..5 are PEND0..PEND2. They appear unchanged on rq_act, rq_autop and rq_pend.
- R8: Payload slots 36..43 carry M0..M7. rq_wmask shows M only for a memory write (OP1,OP0 = 01) and is 8'hFF (all bytes written) otherwise.
- R9: A request is reported only when its device field equals DEV_ID or OP3 is set. Otherwise rq_vld stays 0 and the outputs hold their previous values.
- R10: rq_rsv is 1 when any reserved bit is nonzero. Reserved bits are: command bit-time 7, address bit-times 6..7, bit-times 6..7 on every data wire, and payload slots 33..35 and 44..53.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_pr | input | 2 | Command wire bit pair: [0] rising, [1] falling |
| adr_pr | input | 2 | Address wire bit pair |
| dq_pr | input | 18 | Data wire pairs, wire d at [2d+1:2d] |
| rq_vld | output | 1 | One-cycle pulse for an accepted request |
| rq_write | output | 1 | OP0, write when 1 |
| rq_regsp | output | 1 | OP1, register space when 1 |
| rq_bmopt | output | 1 | OP2 byte-mask option |
| rq_bcast | output | 1 | OP3 broadcast |
| rq_bitm | output | 2 | OP5..OP4 bit-mask options |
| rq_act | output | 1 | Activate flag |
| rq_autop | output | 1 | Auto-precharge flag |
| rq_pend | output | 3 | Pending strobe/terminate skip count |
| rq_dev | output | 15 | Device field, zero-extended |
| rq_bank | output | 2 | Bank field, zero-extended |
| rq_row | output | 10 | Row field, zero-extended |
| rq_col | output | 8 | Column field |
| rq_wmask | output | 8 | Byte write mask for the first octbyte |
| rq_rsv | output | 1 | Nonzero reserved bit seen |

## Verification
The bench drives a memory read with mixed option bits and a nonzero skip count. This shows whether every field lands in its own slot, and whether the pulse comes no earlier or later than one cycle after the fourth beat. It then drives memory and register writes, which separate the masked case from the forced all-ones mask. An operation code with ones in every start position, followed by two requests with no gap between them, tells a correct sequencer from one that restarts or drops a packet. A foreign device ID is sent with and without broadcast, a second instance checks the two-bank split, and single reserved ones in a data slot and in a turnaround bit must each raise the reserved flag.

// File: rtl/rqd_pkg.sv
package rqd_pkg;
   localparam int unsigned PK_BT     = 8;
   localparam int unsigned PK_DQ     = 9;
   localparam int unsigned PK_WIRES  = 2 + PK_DQ;
   localparam int unsigned PK_BITS   = PK_BT * PK_WIRES;
   localparam int unsigned W_CMD     = 0;
   localparam int unsigned W_ADR     = 1;
   localparam int unsigned W_DQ0     = 2;
   localparam int unsigned DQ_SLOTS  = PK_BT - 2;
   localparam int unsigned ADDR_N    = 33;
   localparam int unsigned MASK_SLOT = 36;
   localparam int unsigned MASK_N    = 8;
   localparam int unsigned PAY_N     = PK_DQ * DQ_SLOTS;

   function automatic int unsigned slot_pos(int unsigned k);
      return (W_DQ0 + k / DQ_SLOTS) * PK_BT + k % DQ_SLOTS;
   endfunction

   function automatic logic [PK_BITS-1:0] rsv_mask();
      logic [PK_BITS-1:0] m;
      m = '0;
      m[W_CMD*PK_BT + 7] = 1'b1;
      m[W_ADR*PK_BT + 6] = 1'b1;
      m[W_ADR*PK_BT + 7] = 1'b1;
      for (int d = 0; d < PK_DQ; d++) begin
         m[(W_DQ0+d)*PK_BT + 6] = 1'b1;
         m[(W_DQ0+d)*PK_BT + 7] = 1'b1;
      end
      for (int k = ADDR_N; k < MASK_SLOT; k++) m[slot_pos(k)] = 1'b1;
      for (int k = MASK_SLOT + MASK_N; k < PAY_N; k++) m[slot_pos(k)] = 1'b1;
      return m;
   endfunction

   typedef struct packed {
      logic        write;
      logic        regsp;
      logic        bmopt;
      logic        bcast;
      logic [1:0]  bitm;
      logic        act;
      logic        autop;
      logic [2:0]  pend;
      logic [14:0] dev;
      logic [1:0]  bank;
      logic [9:0]  row;
      logic [7:0]  col;
      logic [7:0]  wmask;
      logic        rsv;
   } req_t;
endpackage

// File: rtl/rqd_gather.sv
module rqd_gather #(
   parameter int unsigned WIRES = 11,
   parameter int unsigned BT    = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [2*WIRES-1:0]    pair_i,
   output logic [WIRES*BT-1:0]   pkt_o,
   output logic                  done_o
);
   localparam int unsigned BEATS = BT / 2;
   localparam int unsigned LAST  = BEATS - 1;
   localparam int unsigned CW    = (BEATS > 1) ? $clog2(BEATS) : 1;

   if (BT % 2 != 0 || BT < 4) begin : g_bad_bt
      $error("rqd_gather: BT must be even and at least 4");
   end

   logic          busy;
   logic [CW-1:0] cnt;
   logic          launch;

   assign launch = !busy && pair_i[0];
   assign done_o = busy && (cnt == CW'(LAST));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (launch) begin
         busy <= 1'b1;
         cnt  <= CW'(1);
      end else if (busy) begin
         cnt <= cnt + 1'b1;
         if (cnt == CW'(LAST)) busy <= 1'b0;
      end
   end

   for (genvar w = 0; w < WIRES; w++) begin : g_wire
      logic [BT-3:0] held;
      for (genvar b = 0; b < LAST; b++) begin : g_beat
         always_ff @(posedge clk) begin
            if ((launch && b == 0) || (busy && cnt == CW'(b)))
               held[2*b +: 2] <= pair_i[2*w +: 2];
         end
      end
      assign pkt_o[w*BT +: BT] = {pair_i[2*w +: 2], held};
   end

   // R3: a finished packet was collected over consecutive busy cycles,
   // so no start bit inside the window restarted the count.
   p_no_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(busy) && $past(busy, 2) && !$past(done_o)));
endmodule

// File: rtl/rqd_split.sv
module rqd_split #(
   parameter bit FOUR_BANK = 1'b1
) (
   input  logic [32:0] abits,
   output logic [14:0] dev,
   output logic [1:0]  bank,
   output logic [9:0]  row,
   output logic [7:0]  col
);
   localparam int unsigned COL_W  = 8;
   localparam int unsigned BANK_W = FOUR_BANK ? 2 : 1;
   localparam int unsigned ROW_W  = FOUR_BANK ? 10 : 9;
   localparam int unsigned DEV_W  = 33 - COL_W - ROW_W - BANK_W;
   localparam int unsigned ROW_LO  = COL_W;
   localparam int unsigned BANK_LO = ROW_LO + ROW_W;
   localparam int unsigned DEV_LO  = BANK_LO + BANK_W;

   assign col = abits[COL_W-1:0];

   if (FOUR_BANK) begin : g_four
      assign row  = abits[ROW_LO +: ROW_W];
      assign bank = abits[BANK_LO +: BANK_W];
      assign dev  = {2'b00, abits[DEV_LO +: DEV_W]};
   end else begin : g_two
      assign row  = {1'b0, abits[ROW_LO +: ROW_W]};
      assign bank = {1'b0, abits[BANK_LO]};
      assign dev  = abits[DEV_LO +: DEV_W];
   end
endmodule

// File: rtl/req_pkt_decoder.sv
module req_pkt_decoder
   import rqd_pkg::*;
#(
   parameter bit          FOUR_BANK = 1'b1,
   parameter int unsigned DEV_ID    = 32'h0A5
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  cmd_pr,
   input  logic [1:0]  adr_pr,
   input  logic [17:0] dq_pr,
   output logic        rq_vld,
   output logic        rq_write,
   output logic        rq_regsp,
   output logic        rq_bmopt,
   output logic        rq_bcast,
   output logic [1:0]  rq_bitm,
   output logic        rq_act,
   output logic        rq_autop,
   output logic [2:0]  rq_pend,
   output logic [14:0] rq_dev,
   output logic [1:0]  rq_bank,
   output logic [9:0]  rq_row,
   output logic [7:0]  rq_col,
   output logic [7:0]  rq_wmask,
   output logic        rq_rsv
);
   localparam int unsigned DEV_W = FOUR_BANK ? 13 : 15;
   localparam logic [PK_BITS-1:0] RSV_MASK = rsv_mask();

   if (DEV_ID >= (32'd1 << DEV_W)) begin : g_bad_id
      $error("req_pkt_decoder: DEV_ID does not fit the device field");
   end

   logic [PK_BITS-1:0] pkt;
   logic               done;
   logic [ADDR_N-1:0]  abits;
   logic [MASK_N-1:0]  mbits;
   logic [5:0]         op;
   req_t               dec, held;
   logic               accept;
   logic               vld_q;

   rqd_gather #(.WIRES(PK_WIRES), .BT(PK_BT)) u_gather (
      .clk    (clk),
      .rst_n  (rst_n),
      .pair_i ({dq_pr, adr_pr, cmd_pr}),
      .pkt_o  (pkt),
      .done_o (done)
   );

   for (genvar i = 0; i < ADDR_N; i++) begin : g_abit
      assign abits[i] = pkt[slot_pos(i)];
   end
   for (genvar j = 0; j < MASK_N; j++) begin : g_mbit
      assign mbits[j] = pkt[slot_pos(MASK_SLOT + j)];
   end
   for (genvar j = 0; j < 6; j++) begin : g_op
      assign op[j] = pkt[W_CMD*PK_BT + 1 + j];
   end

   rqd_split #(.FOUR_BANK(FOUR_BANK)) u_split (
      .abits (abits),
      .dev   (dec.dev),
      .bank  (dec.bank),
      .row   (dec.row),
      .col   (dec.col)
   );

   always_comb begin
      dec.write = op[0];
      dec.regsp = op[1];
      dec.bmopt = op[2];
      dec.bcast = op[3];
      dec.bitm  = op[5:4];
      dec.act   = pkt[W_ADR*PK_BT + 0];
      dec.autop = pkt[W_ADR*PK_BT + 1];
      dec.pend  = pkt[W_ADR*PK_BT + 3 +: 3];
      dec.wmask = (op[1:0] == 2'b01) ? mbits : 8'hFF;
      dec.rsv   = |(pkt & RSV_MASK);
   end

   assign accept = done && ((dec.dev == 15'(DEV_ID)) || dec.bcast);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         held  <= '0;
      end else begin
         vld_q <= accept;
         if (accept) held <= dec;
      end
   end

   assign rq_vld   = vld_q;
   assign rq_write = held.write;
   assign rq_regsp = held.regsp;
   assign rq_bmopt = held.bmopt;
   assign rq_bcast = held.bcast;
   assign rq_bitm  = held.bitm;
   assign rq_act   = held.act;
   assign rq_autop = held.autop;
   assign rq_pend  = held.pend;
   assign rq_dev   = held.dev;
   assign rq_bank  = held.bank;
   assign rq_row   = held.row;
   assign rq_col   = held.col;
   assign rq_wmask = held.wmask;
   assign rq_rsv   = held.rsv;

   // R2: a request occupies four cycles, so a valid pulse never repeats back to back.
   p_vld_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rq_vld |=> !rq_vld);

   // R9: every reported request is addressed to this device or broadcast.
   p_dev_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rq_vld |-> (rq_dev == 15'(DEV_ID) || rq_bcast));

   // R8: anything but a memory write reports a full byte mask.
   p_wmask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rq_vld && !(rq_write && !rq_regsp)) |-> (rq_wmask == 8'hFF));

   // R1: outputs stay clear until the first accepted request.
   p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!rst_n) && !rq_vld) |-> (rq_dev == '0 && rq_wmask == '0));
endmodule

// File: tb/sim_req_pkt_decoder.sv
`timescale 1ns/1ps
module sim_req_pkt_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cmd_pr = '0;
   logic [1:0]  adr_pr = '0;
   logic [17:0] dq_pr = '0;

   logic        vld, wr, rs, bmo, bc, act, aup, rsv;
   logic [1:0]  bitm, bank;
   logic [2:0]  pend;
   logic [14:0] dev;
   logic [9:0]  row;
   logic [7:0]  col, wm;

   logic        vld_b, wr_b, rs_b, bmo_b, bc_b, act_b, aup_b, rsv_b;
   logic [1:0]  bitm_b, bank_b;
   logic [2:0]  pend_b;
   logic [14:0] dev_b;
   logic [9:0]  row_b;
   logic [7:0]  col_b, wm_b;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   req_pkt_decoder #(.FOUR_BANK(1'b1), .DEV_ID(32'h0A5)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_pr(cmd_pr), .adr_pr(adr_pr), .dq_pr(dq_pr),
      .rq_vld(vld), .rq_write(wr), .rq_regsp(rs), .rq_bmopt(bmo), .rq_bcast(bc),
      .rq_bitm(bitm), .rq_act(act), .rq_autop(aup), .rq_pend(pend), .rq_dev(dev),
      .rq_bank(bank), .rq_row(row), .rq_col(col), .rq_wmask(wm), .rq_rsv(rsv));

   req_pkt_decoder #(.FOUR_BANK(1'b0), .DEV_ID(32'h4D21)) u1 (
      .clk(clk), .rst_n(rst_n), .cmd_pr(cmd_pr), .adr_pr(adr_pr), .dq_pr(dq_pr),
      .rq_vld(vld_b), .rq_write(wr_b), .rq_regsp(rs_b), .rq_bmopt(bmo_b), .rq_bcast(bc_b),
      .rq_bitm(bitm_b), .rq_act(act_b), .rq_autop(aup_b), .rq_pend(pend_b), .rq_dev(dev_b),
      .rq_bank(bank_b), .rq_row(row_b), .rq_col(col_b), .rq_wmask(wm_b), .rq_rsv(rsv_b));

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   function automatic int spos(input int k);
      return (2 + k / 6) * 8 + k % 6;
   endfunction

   function automatic logic [87:0] mk(input logic [5:0] op, input logic a_act, input logic a_aut,
                                      input logic a_rs, input logic [2:0] a_pend,
                                      input logic [35:0] a, input logic [7:0] m);
      logic [87:0] pk;
      pk = '0;
      pk[0] = 1'b1;
      for (int j = 0; j < 6; j++) pk[1+j] = op[j];
      pk[8]  = a_act;
      pk[9]  = a_aut;
      pk[10] = a_rs;
      for (int j = 0; j < 3; j++) pk[11+j] = a_pend[j];
      for (int i = 0; i < 33; i++) pk[spos(i)] = a[3+i];
      for (int j = 0; j < 8; j++) pk[spos(36+j)] = m[j];
      return pk;
   endfunction

   function automatic logic [35:0] a4(input logic [12:0] d, input logic [1:0] b,
                                      input logic [9:0] r, input logic [7:0] c);
      return {d, b, r, c, 3'b000};
   endfunction

   function automatic logic [35:0] a2(input logic [14:0] d, input logic b,
                                      input logic [8:0] r, input logic [7:0] c);
      return {d, b, r, c, 3'b000};
   endfunction

   task automatic drive(input logic [87:0] pk);
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         cmd_pr = {pk[2*c+1], pk[2*c]};
         adr_pr = {pk[8+2*c+1], pk[8+2*c]};
         for (int d = 0; d < 9; d++)
            dq_pr[2*d +: 2] = {pk[(2+d)*8+2*c+1], pk[(2+d)*8+2*c]};
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cmd_pr = '0;
         adr_pr = '0;
         dq_pr  = '0;
      end
   endtask

   task automatic at_out();
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      drive(mk(6'b000000, 1'b1, 1'b0, 1'b0, 3'd0, a4(13'h0A5, 2'd1, 10'd3, 8'd4), 8'h00));
      at_out();
      chk("R1 vld in reset", vld, 0);
      chk("R1 dev in reset", dev, 0);
      chk("R1 wmask in reset", wm, 0);
      idle(1);
      rst_n = 1'b1;
      idle(2);
      at_out();
      chk("R1 vld after reset", vld, 0);
      chk("R1 col after reset", col, 0);
   endtask

   task automatic t_read4();
      idle(1);
      drive(mk(6'b100100, 1'b1, 1'b0, 1'b0, 3'b101, a4(13'h0A5, 2'd2, 10'h2C3, 8'h5A), 8'h77));
      chk("R2 no early vld", vld, 0);
      at_out();
      chk("R2 vld after beat 3", vld, 1);
      chk("R4 dev", dev, 15'h0A5);
      chk("R4 bank", bank, 2);
      chk("R4 row", row, 10'h2C3);
      chk("R4 col", col, 8'h5A);
      chk("R6 write", wr, 0);
      chk("R6 regsp", rs, 0);
      chk("R6 bmopt", bmo, 1);
      chk("R6 bcast", bc, 0);
      chk("R6 bitm", bitm, 2'b10);
      chk("R7 act", act, 1);
      chk("R7 autop", aup, 0);
      chk("R7 pend", pend, 3'b101);
      chk("R8 read mask", wm, 8'hFF);
      chk("R10 clean", rsv, 0);
      idle(1);
      at_out();
      chk("R2 vld one cycle", vld, 0);
   endtask

   task automatic t_write();
      idle(1);
      drive(mk(6'b000001, 1'b0, 1'b1, 1'b0, 3'd0, a4(13'h0A5, 2'd0, 10'h001, 8'h10), 8'h3C));
      at_out();
      chk("R8 mem write vld", vld, 1);
      chk("R8 mem write mask", wm, 8'h3C);
      chk("R6 mem write bit", wr, 1);
      chk("R7 autop set", aup, 1);
      chk("R7 pend zero", pend, 0);
      idle(1);
      drive(mk(6'b000011, 1'b0, 1'b0, 1'b1, 3'd0, a4(13'h0A5, 2'd0, 10'h001, 8'h11), 8'h3C));
      at_out();
      chk("R8 reg write vld", vld, 1);
      chk("R8 reg write mask", wm, 8'hFF);
      chk("R6 reg space", rs, 1);
   endtask

   task automatic t_restart();
      idle(1);
      // OP1, OP3, OP5 sit in the start position of cycles 1..3
      drive(mk(6'b101010, 1'b0, 1'b0, 1'b0, 3'd2, a4(13'h0A5, 2'd3, 10'h155, 8'hA1), 8'h00));
      at_out();
      chk("R3 vld once", vld, 1);
      chk("R3 col kept", col, 8'hA1);
      chk("R3 bitm", bitm, 2'b10);
      chk("R3 bcast", bc, 1);
      idle(1);
      at_out();
      chk("R3 no restart pulse", vld, 0);
      idle(2);
      drive(mk(6'b000000, 1'b0, 1'b0, 1'b0, 3'd1, a4(13'h0A5, 2'd1, 10'h0F0, 8'hB2), 8'h00));
      at_out();
      chk("R3 first of pair", vld, 1);
      chk("R3 first col", col, 8'hB2);
      drive(mk(6'b000000, 1'b0, 1'b0, 1'b0, 3'd4, a4(13'h0A5, 2'd2, 10'h00F, 8'hB3), 8'h00));
      chk("R3 gap inside second", vld, 0);
      at_out();
      chk("R3 second of pair", vld, 1);
      chk("R3 second col", col, 8'hB3);
      chk("R3 second pend", pend, 4);
   endtask

   task automatic t_dev();
      idle(1);
      drive(mk(6'b000000, 1'b0, 1'b0, 1'b0, 3'd0, a4(13'h0A4, 2'd1, 10'h3FF, 8'hC4), 8'h00));
      at_out();
      chk("R9 foreign dropped", vld, 0);
      chk("R9 outputs held", col, 8'hB3);
      idle(1);
      drive(mk(6'b001000, 1'b0, 1'b0, 1'b0, 3'd0, a4(13'h0A4, 2'd1, 10'h3FF, 8'hC5), 8'h00));
      at_out();
      chk("R9 broadcast taken", vld, 1);
      chk("R9 broadcast dev", dev, 15'h0A4);
      chk("R9 broadcast row", row, 10'h3FF);
   endtask

   task automatic t_two();
      idle(1);
      drive(mk(6'b000000, 1'b1, 1'b1, 1'b0, 3'd6, a2(15'h4D21, 1'b1, 9'h1B7, 8'hC3), 8'h00));
      at_out();
      chk("R5 vld", vld_b, 1);
      chk("R5 dev", dev_b, 15'h4D21);
      chk("R5 bank", bank_b, 1);
      chk("R5 row", row_b, 10'h1B7);
      chk("R5 col", col_b, 8'hC3);
      chk("R5 pend", pend_b, 6);
   endtask

   task automatic t_rsv();
      logic [87:0] pk;
      idle(1);
      pk = mk(6'b000000, 1'b0, 1'b0, 1'b0, 3'd0, a4(13'h0A5, 2'd0, 10'h002, 8'hD0), 8'h00);
      pk[spos(50)] = 1'b1;
      drive(pk);
      at_out();
      chk("R10 slot 50 vld", vld, 1);
      chk("R10 slot 50 flag", rsv, 1);
      idle(1);
      pk = mk(6'b000000, 1'b0, 1'b0, 1'b0, 3'd0, a4(13'h0A5, 2'd0, 10'h002, 8'hD1), 8'h00);
      pk[(2+3)*8+7] = 1'b1;
      drive(pk);
      at_out();
      chk("R10 turnaround flag", rsv, 1);
      idle(1);
      drive(mk(6'b000000, 1'b0, 1'b0, 1'b0, 3'd0, a4(13'h0A5, 2'd0, 10'h002, 8'hD2), 8'h00));
      at_out();
      chk("R10 flag clears", rsv, 0);
   endtask

   initial begin
      t_reset();
      t_read4();
      t_write();
      t_restart();
      t_dev();
      t_two();
      t_rsv();
      idle(2);
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog R1-all actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule